// File: doc/BRIEF.md
# Multi-Channel Playback Sequencer

This block keeps the control state of eight independent playback channels. Each channel can play one phrase at a time, hold one more item (a phrase or a timed silence) queued behind it, and repeat its phrase while its loop bit is set. A host issues one command per cycle: an opcode, a channel mask and an operand byte. The per-channel sample decoders receive a one-cycle launch pulse whenever a phrase must begin or restart, a play level while a phrase is running, and a one-cycle halt pulse when playback is cut off. The decoders answer with an end-of-phrase pulse.

Two status vectors are kept apart. The ready flag shows that the channel's queue slot is free, so the host may hand it the next item. The idle flag shows that the channel is neither playing, nor counting silence, nor holding a queued item. Silence length is counted in ticks from a shared divider of the master clock; each tick stands for 4.096 ms of real time when the divider matches the clock rate.

Top module: `pbseq_top`

## Requirements
- R1: A start command (opcode 0) puts a phrase into the slot of every masked channel whose ready flag is high. On an idle channel, ready and idle go low the cycle after the command, and one cycle later launch pulses for one cycle, play goes high and ready returns high. All channels named in one mask launch in the same cycle.
- R2: A stop command (opcode 1) on a masked channel clears its phrase, its silence and its queued item. The next cycle shows play and mute low, ready and idle high, and halt high for exactly one cycle. Stop has priority over every other event on that channel.
- R3: A start or silence command that reaches a channel whose ready flag is low has no effect on that channel.
- R4: Idle is high only when the channel has no phrase running, no silence running and nothing queued. Reset leaves every channel idle and ready, with loop bits clear.
- R5: A queued item is taken at the phrase boundary. An end-of-phrase pulse on a playing channel with a queued phrase and a clear loop bit gives a launch pulse in the next cycle, with play still high and ready high again.
- R6: A loop command (opcode 2) writes the mask into the loop bits of all eight channels. An end-of-phrase pulse on a playing channel whose loop bit is set relaunches the same phrase and leaves the queued item in place.
- R7: Clearing a loop bit lets the current repetition finish. The next end-of-phrase pulse then takes the queued item, or stops play when nothing is queued.
- R8: A silence command (opcode 3) queues a silence of M ticks, with M taken from the operand byte. It starts at once on an idle channel, or after the current phrase ends on a playing channel. The mute flag is high while the silence is running and is never high together with play.
- R9: A silence command with an operand of zero is ignored.
- R10: A free-running divider produces one tick every TICK_DIV clock cycles. A silence of M ticks ends on the M-th tick after it starts, so mute stays high for more than (M-1)·TICK_DIV cycles and at most M·TICK_DIV cycles.
- R11: An end-of-phrase pulse on a channel that is not playing a phrase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 2 | Opcode: 0 start, 1 stop, 2 loop, 3 silence |
| cmd_mask_i | input | NCH | Channel mask, bit n selects channel n |
| cmd_len_i | input | LEN_W | Silence length in ticks |
| phr_end_i | input | NCH | End-of-phrase pulses from the decoders |
| rdy_o | output | NCH | Queue slot free |
| idle_o | output | NCH | Nothing playing, silent or queued |
| play_o | output | NCH | Phrase running |
| mute_o | output | NCH | Timed silence running |
| launch_o | output | NCH | One-cycle pulse: start or restart the phrase |
| halt_o | output | NCH | One-cycle pulse: abort and return to mid-scale |

## Verification
The bound checker watches every channel on every cycle. It checks the response one cycle after a stop, that a start on an idle channel pulls ready and idle low, that idle never coexists with play, mute or a full slot, and that play and mute never overlap. It also checks that a zero-length silence and a stray end pulse leave an idle channel idle. Queue handover at phrase boundaries, loop release after the current repetition, requests ignored while the slot is full, and the silence duration window depend on sequences of events over many cycles. The bench shows these with directed scenarios and a cycle-by-cycle model under random traffic.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
  localparam int OP_W = 2;
  typedef enum logic [OP_W-1:0] {
    OP_START   = 2'd0,
    OP_STOP    = 2'd1,
    OP_LOOP    = 2'd2,
    OP_SILENCE = 2'd3
  } op_e;
endpackage

// File: rtl/pbseq_tick.sv
module pbseq_tick #(
  parameter int TICK_DIV = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pbseq_chan.sv
module pbseq_chan #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sil_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             loop_i,
  input  logic             end_i,
  output logic             rdy_o,
  output logic             idle_o,
  output logic             play_o,
  output logic             mute_o,
  output logic             launch_o,
  output logic             halt_o
);
  typedef struct packed {
    logic             vld;
    logic             sil;
    logic [LEN_W-1:0] len;
  } slot_t;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             phr_q, phr_d;
  logic             sil_q, sil_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  slot_t            slot_q, slot_d;
  logic             go_q, go_d;
  logic             halt_q, halt_d;

  always_comb begin
    phr_d  = phr_q;
    sil_d  = sil_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    go_d   = 1'b0;
    halt_d = 1'b0;
    if (stop_i) begin
      phr_d  = 1'b0;
      sil_d  = 1'b0;
      cnt_d  = '0;
      slot_d = '0;
      halt_d = 1'b1;
    end else begin
      // phrase boundary: replay or retire
      if (phr_q && end_i) begin
        if (loop_i) go_d  = 1'b1;
        else        phr_d = 1'b0;
      end
      if (sil_q && tick_i) begin
        if (cnt_q == ONE) begin
          sil_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      // hand queued item over once the channel is free
      if (slot_q.vld && !phr_d && !sil_d) begin
        if (slot_q.sil) begin
          sil_d = 1'b1;
          cnt_d = slot_q.len;
        end else begin
          phr_d = 1'b1;
          go_d  = 1'b1;
        end
        slot_d.vld = 1'b0;
      end
      // new requests only land in an empty slot
      if (!slot_q.vld) begin
        if (start_i)
          slot_d = '{vld: 1'b1, sil: 1'b0, len: '0};
        else if (sil_i && (len_i != '0))
          slot_d = '{vld: 1'b1, sil: 1'b1, len: len_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phr_q  <= 1'b0;
      sil_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      go_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      phr_q  <= phr_d;
      sil_q  <= sil_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      go_q   <= go_d;
      halt_q <= halt_d;
    end
  end

  assign rdy_o    = ~slot_q.vld;
  assign idle_o   = ~(phr_q | sil_q | slot_q.vld);
  assign play_o   = phr_q;
  assign mute_o   = sil_q;
  assign launch_o = go_q;
  assign halt_o   = halt_q;
endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
  import pbseq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int LEN_W    = 8,
  parameter int TICK_DIV = 16384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [OP_W-1:0]  cmd_op_i,
  input  logic [NCH-1:0]   cmd_mask_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [NCH-1:0]   phr_end_i,
  output logic [NCH-1:0]   rdy_o,
  output logic [NCH-1:0]   idle_o,
  output logic [NCH-1:0]   play_o,
  output logic [NCH-1:0]   mute_o,
  output logic [NCH-1:0]   launch_o,
  output logic [NCH-1:0]   halt_o
);
  logic           tick;
  logic [NCH-1:0] loop_q;
  logic           is_start, is_stop, is_loop, is_sil;

  assign is_start = cmd_vld_i && (op_e'(cmd_op_i) == OP_START);
  assign is_stop  = cmd_vld_i && (op_e'(cmd_op_i) == OP_STOP);
  assign is_loop  = cmd_vld_i && (op_e'(cmd_op_i) == OP_LOOP);
  assign is_sil   = cmd_vld_i && (op_e'(cmd_op_i) == OP_SILENCE);

  pbseq_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      loop_q <= '0;
    else if (is_loop) loop_q <= cmd_mask_i;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pbseq_chan #(.LEN_W(LEN_W)) chan_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .start_i  (is_start && cmd_mask_i[n]),
      .stop_i   (is_stop && cmd_mask_i[n]),
      .sil_i    (is_sil && cmd_mask_i[n]),
      .len_i    (cmd_len_i),
      .loop_i   (loop_q[n]),
      .end_i    (phr_end_i[n]),
      .rdy_o    (rdy_o[n]),
      .idle_o   (idle_o[n]),
      .play_o   (play_o[n]),
      .mute_o   (mute_o[n]),
      .launch_o (launch_o[n]),
      .halt_o   (halt_o[n])
    );
  end
endmodule

// File: rtl/pbseq_chk.sv
module pbseq_chk
  import pbseq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_vld_i,
  input logic [OP_W-1:0]  cmd_op_i,
  input logic [NCH-1:0]   cmd_mask_i,
  input logic [LEN_W-1:0] cmd_len_i,
  input logic [NCH-1:0]   phr_end_i,
  input logic [NCH-1:0]   rdy_o,
  input logic [NCH-1:0]   idle_o,
  input logic [NCH-1:0]   play_o,
  input logic [NCH-1:0]   mute_o,
  input logic [NCH-1:0]   launch_o,
  input logic [NCH-1:0]   halt_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_prop
    p_start_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_vld_i && (cmd_op_i == OP_START) && cmd_mask_i[g] && idle_o[g]
      |=> !rdy_o[g] && !idle_o[g]);

    p_launch_play_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch_o[g] |-> play_o[g]);

    p_stop_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_vld_i && (cmd_op_i == OP_STOP) && cmd_mask_i[g]
      |=> rdy_o[g] && idle_o[g] && !play_o[g] && !mute_o[g] && halt_o[g]);

    p_idle_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o[g] |-> rdy_o[g] && !play_o[g] && !mute_o[g]);

    p_play_mute_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({play_o[g], mute_o[g]}));

    p_zero_silence_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_vld_i && (cmd_op_i == OP_SILENCE) && cmd_mask_i[g] &&
      (cmd_len_i == '0) && idle_o[g]
      |=> idle_o[g]);

    p_stray_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o[g] && phr_end_i[g] && !cmd_vld_i
      |=> idle_o[g] && !launch_o[g]);
  end
endmodule

bind pbseq_top pbseq_chk #(.NCH(NCH), .LEN_W(LEN_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_vld_i  (cmd_vld_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_mask_i (cmd_mask_i),
  .cmd_len_i  (cmd_len_i),
  .phr_end_i  (phr_end_i),
  .rdy_o      (rdy_o),
  .idle_o     (idle_o),
  .play_o     (play_o),
  .mute_o     (mute_o),
  .launch_o   (launch_o),
  .halt_o     (halt_o)
);

// File: tb/pbseq_top_tb_top.sv
module pbseq_top_tb_top;
  localparam int NCH = 8;
  localparam int LW  = 8;
  localparam int DIV = 8;
  // R12-free opcode map, as given in R1, R2, R6, R8
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_LOOP = 2'd2, C_SIL = 2'd3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic           cmd_vld = 1'b0;
  logic [1:0]     cmd_op = '0;
  logic [NCH-1:0] cmd_mask = '0;
  logic [LW-1:0]  cmd_len = '0;
  logic [NCH-1:0] phr_end = '0;
  logic [NCH-1:0] rdy_o, idle_o, play_o, mute_o, launch_o, halt_o;

  pbseq_top #(.NCH(NCH), .LEN_W(LW), .TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op),
    .cmd_mask_i(cmd_mask), .cmd_len_i(cmd_len), .phr_end_i(phr_end),
    .rdy_o(rdy_o), .idle_o(idle_o), .play_o(play_o), .mute_o(mute_o),
    .launch_o(launch_o), .halt_o(halt_o)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [NCH-1:0] m_phr = '0, m_sil = '0, m_pv = '0, m_ps = '0, m_loop = '0;
  logic [NCH-1:0] m_go = '0, m_halt = '0;
  logic [LW-1:0]  m_cnt [NCH];
  logic [LW-1:0]  m_pl  [NCH];
  int m_div = 0;

  function automatic logic [NCH-1:0] exp_idle();
    return ~(m_phr | m_sil | m_pv);
  endfunction

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R3 R5 ready", rdy_o, ~m_pv);
    chk("R4 idle", idle_o, exp_idle());
    chk("R1 play", play_o, m_phr);
    chk("R8 mute", mute_o, m_sil);
    chk("R6 launch", launch_o, m_go);
    chk("R2 halt", halt_o, m_halt);
  endtask

  // reference model of one clock edge, written from the requirements
  task automatic model_step(bit v, logic [1:0] op, logic [NCH-1:0] mask,
                            logic [LW-1:0] len, logic [NCH-1:0] endv);
    bit tk = (m_div == DIV - 1);
    m_div = tk ? 0 : m_div + 1;
    for (int c = 0; c < NCH; c++) begin
      bit old_rdy = !m_pv[c];
      m_go[c] = 1'b0;
      m_halt[c] = 1'b0;
      if (v && op == C_STOP && mask[c]) begin
        m_phr[c] = 0; m_sil[c] = 0; m_pv[c] = 0; m_cnt[c] = '0;
        m_halt[c] = 1'b1;
      end else begin
        if (m_phr[c] && endv[c]) begin
          if (m_loop[c]) m_go[c] = 1'b1;
          else m_phr[c] = 1'b0;
        end
        if (m_sil[c] && tk) begin
          if (m_cnt[c] == 1) begin m_sil[c] = 0; m_cnt[c] = '0; end
          else m_cnt[c] = m_cnt[c] - 1;
        end
        if (m_pv[c] && !m_phr[c] && !m_sil[c]) begin
          if (m_ps[c]) begin m_sil[c] = 1; m_cnt[c] = m_pl[c]; end
          else begin m_phr[c] = 1; m_go[c] = 1; end
          m_pv[c] = 0;
        end
        if (old_rdy && v && mask[c]) begin
          if (op == C_START) begin m_pv[c] = 1; m_ps[c] = 0; end
          else if (op == C_SIL && len != 0) begin m_pv[c] = 1; m_ps[c] = 1; m_pl[c] = len; end
        end
      end
    end
    if (v && op == C_LOOP) m_loop = mask;
  endtask

  task automatic drive(bit v, logic [1:0] op, logic [NCH-1:0] mask,
                       logic [LW-1:0] len, logic [NCH-1:0] endv);
    cmd_vld = v; cmd_op = op; cmd_mask = mask; cmd_len = len; phr_end = endv;
    model_step(v, op, mask, len, endv);
    @(negedge clk);
    compare();
  endtask

  task automatic nop();
    drive(1'b0, 2'd0, '0, '0, '0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    int mute_len;
    seed = $urandom(32'd1357);
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = '0; m_pl[c] = '0; end
    repeat (3) @(negedge clk);
    compare();                                    // R4 reset state
    rst_ni = 1'b1;

    // R1: all channels from idle in one mask
    drive(1, C_START, 8'hFF, 0, 0);
    chk("R1 ready low after start", rdy_o, 8'h00);
    chk("R1 idle low after start", idle_o, 8'h00);
    nop();
    chk("R1 launch together", launch_o, 8'hFF);
    chk("R1 play together", play_o, 8'hFF);
    chk("R1 ready back", rdy_o, 8'hFF);
    nop();
    chk("R1 launch single cycle", launch_o, 8'h00);

    // R5 and R3 on channel 0
    drive(1, C_START, 8'h01, 0, 0);
    chk("R5 slot taken", rdy_o & 8'h01, 8'h00);
    drive(1, C_START, 8'h01, 0, 0);               // R3: slot full, ignored
    drive(0, 0, 0, 0, 8'h01);
    chk("R5 launch at boundary", launch_o & 8'h01, 8'h01);
    chk("R5 play held", play_o & 8'h01, 8'h01);
    chk("R5 ready after handover", rdy_o & 8'h01, 8'h01);
    drive(0, 0, 0, 0, 8'h01);
    chk("R3 second start ignored", idle_o & 8'h01, 8'h01);

    // R11: end pulse on an idle channel
    drive(0, 0, 0, 0, 8'h01);
    chk("R11 stray end idle", idle_o & 8'h01, 8'h01);
    chk("R11 stray end no launch", launch_o & 8'h01, 8'h00);

    // R6 and R7 on channel 1
    drive(1, C_LOOP, 8'h02, 0, 0);
    drive(0, 0, 0, 0, 8'h02);
    chk("R6 loop relaunch", launch_o & 8'h02, 8'h02);
    chk("R6 loop keeps play", play_o & 8'h02, 8'h02);
    drive(1, C_START, 8'h02, 0, 0);
    drive(1, C_LOOP, 8'h00, 0, 0);
    drive(0, 0, 0, 0, 8'h02);
    chk("R7 queued phrase after last repeat", launch_o & 8'h02, 8'h02);
    chk("R7 slot consumed", rdy_o & 8'h02, 8'h02);
    drive(0, 0, 0, 0, 8'h02);
    chk("R7 loop released, play ends", idle_o & 8'h02, 8'h02);

    // R8 and R10 on channel 2: silence queued behind a phrase
    drive(1, C_SIL, 8'h04, 3, 0);
    chk("R8 silence queued", rdy_o & 8'h04, 8'h00);
    chk("R8 silence waits for phrase", mute_o & 8'h04, 8'h00);
    drive(0, 0, 0, 0, 8'h04);
    chk("R8 silence after phrase", mute_o & 8'h04, 8'h04);
    chk("R8 busy during silence", idle_o & 8'h04, 8'h00);
    mute_len = 1;
    for (int k = 0; k < 100 && mute_o[2]; k++) begin
      nop();
      if (mute_o[2]) mute_len++;
    end
    n_chk++;
    if (mute_len <= 2 * DIV || mute_len > 3 * DIV) begin
      n_err++;
      $display("FAIL R10 silence length act=%0d exp=(%0d..%0d]", mute_len, 2 * DIV, 3 * DIV);
    end
    chk("R10 idle after silence", idle_o & 8'h04, 8'h04);

    // R9 on idle channel 0
    drive(1, C_SIL, 8'h01, 0, 0);
    chk("R9 zero silence ready", rdy_o & 8'h01, 8'h01);
    chk("R9 zero silence idle", idle_o & 8'h01, 8'h01);

    // R2 on channel 4: playing with a queued start
    drive(1, C_START, 8'h10, 0, 0);
    drive(1, C_STOP, 8'h10, 0, 0);
    chk("R2 halt pulse", halt_o & 8'h10, 8'h10);
    chk("R2 idle after stop", idle_o & 8'h10, 8'h10);
    nop();
    nop();
    chk("R2 halt single cycle", halt_o & 8'h10, 8'h00);
    chk("R2 queued start dropped", play_o & 8'h10, 8'h00);

    drive(1, C_STOP, 8'hFF, 0, 0);
    nop();

    // constrained random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      bit v;
      int r;
      logic [1:0] op;
      logic [NCH-1:0] mask;
      v = ($urandom % 3) == 0;
      r = $urandom % 10;
      op = (r < 4) ? C_START : (r == 4) ? C_STOP : (r < 7) ? C_LOOP : C_SIL;
      mask = NCH'($urandom);
      if (op == C_STOP) mask = mask & NCH'($urandom) & NCH'($urandom);
      drive(v, op, mask, LW'($urandom % 5), NCH'($urandom) & NCH'($urandom));
    end

    summary();
    $finish;
  end
endmodule